// File: doc/BRIEF.md
# Debug Stepping Command Sequencer

This block sits between the byte stream of a serial debug link and the halted core of a small 8-bit processor. Bytes arrive already assembled, each marked by a one-cycle valid strobe. The block recognises three stepping commands and turns each into a single request pulse towards the core. Each request carries the instruction bytes the host supplied, how many there are, and whether the rest of the instruction comes from program memory.

Every stepping command is accepted only while the core is in debug mode and the flash read lock is clear. A command that arrives while either condition fails is refused. The execute command is the exception: when refused, it still swallows exactly one following byte.

The block also owns an 8-bit debug control word. Through it a host enters or leaves debug mode, enables the breakpoint instruction, and pulses a reset of the device.

Top module: `dbg_step_ctl`

## Requirements
- R1: After reset `step_o`, `dev_rst_o` and all of `ctl_rdata_o` except bit 5 are 0, and `ctl_rdata_o[5]` follows `cpu_halted_i`.
- R2: When enabled (debug mode set and `rd_protect_i` low), command byte 10h produces `step_o` high in the cycle after the byte, with `fetch_rest_o`=1 and `inj_len_o`=0.
- R3: When enabled, command byte 11h followed by one payload byte produces `step_o` in the cycle after the payload. It comes with `fetch_rest_o`=1, `inj_len_o`=1 and the payload in `inj_bytes_o[7:0]`.
- R4: When enabled, command byte 12h is followed by an opcode byte. The instruction length is ((opcode[7:4] mod 5) + 1) bytes. `step_o` rises in the cycle after the last byte, with `fetch_rest_o`=0, `inj_len_o` equal to the length, and byte k in `inj_bytes_o[8k+7:8k]`, the opcode being byte 0.
- R5: When not enabled, command bytes 10h and 11h have no effect. The next byte is again taken as a command.
- R6: When not enabled, command byte 12h discards exactly one following byte without any request. The byte after that is taken as a command.
- R7: A byte other than 10h, 11h or 12h received while idle is dropped without a request.
- R8: Commands are decoded only when idle. Bytes received while a payload is being collected are payload, even if they equal a command code. Back-to-back commands each produce their own request.
- R9: A write to the control word stores bit 7 (debug mode) and bit 6 (breakpoint enable), both visible from the next cycle. Bits 4..1 read 0, and bit 5 is read-only and mirrors `cpu_halted_i`.
- R10: Writing bit 0 as 1 drives `dev_rst_o` high for exactly the next cycle, with `ctl_rdata_o[0]` reading 1 during that cycle only. The debug mode bit written in the same word is kept. So 81h resets and stops, 41h resets and runs, and 40h leaves debug mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_valid_i | input | 1 | Byte strobe from the debug link |
| rx_byte_i | input | 8 | Received byte |
| rd_protect_i | input | 1 | Flash read lock; blocks stepping commands |
| cpu_halted_i | input | 1 | Core acknowledges it is halted (read as bit 5) |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 8 | Control word write data |
| ctl_rdata_o | output | 8 | Control word read value |
| dev_rst_o | output | 1 | One-cycle device reset pulse |
| step_o | output | 1 | One-cycle instruction step request |
| fetch_rest_o | output | 1 | Remaining instruction bytes come from program memory |
| inj_len_o | output | 3 | Number of valid injected bytes |
| inj_bytes_o | output | 40 | Injected bytes, byte 0 in bits 7..0 |

## Verification
The bench targets refused execute commands. A design that discards zero or two bytes shifts every later command by one byte, so the step following the refused command either appears early or vanishes. Payload bytes that equal command codes are sent on purpose, which exposes a sequencer that decodes them as commands and issues requests too soon. The length rule is swept across opcodes whose nibble wraps around 5, such as 50h and F0h, because an off-by-one length waits forever or truncates. Reset writes check that the debug mode bit written alongside the reset bit survives, and that the pulse is a single cycle.

// File: rtl/dbgseq_pkg.sv
package dbgseq_pkg;

    localparam int INSTR_MAX = 5;
    localparam int BYTE_W    = 8;
    localparam int LEN_W     = $clog2(INSTR_MAX + 1);

    localparam logic [BYTE_W-1:0] CMD_STEP  = 8'h10;
    localparam logic [BYTE_W-1:0] CMD_STUFF = 8'h11;
    localparam logic [BYTE_W-1:0] CMD_EXEC  = 8'h12;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STUFF,
        S_OPC,
        S_BODY,
        S_DROP
    } seq_state_e;

    // Instruction length from the upper opcode nibble: (nibble mod max) + 1
    function automatic logic [LEN_W-1:0] op_len(input logic [3:0] nib);
        logic [3:0] r;
        r = nib % 4'(INSTR_MAX);
        return LEN_W'(r) + LEN_W'(1);
    endfunction

endpackage

// File: rtl/dbg_ctl_reg.sv
module dbg_ctl_reg
    import dbgseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              halted_i,
    output logic [BYTE_W-1:0] rdata_o,
    output logic              mode_o,
    output logic              rst_pulse_o
);

    typedef struct packed {
        logic mode;
        logic brk;
        logic rst;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic unused_wbits;
    assign unused_wbits = ^wdata_i[5:1];

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.rst = 1'b0;
        if (we_i) begin
            ctl_d.mode = wdata_i[7];
            ctl_d.brk  = wdata_i[6];
            ctl_d.rst  = wdata_i[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign rdata_o     = {ctl_q.mode, ctl_q.brk, halted_i, 4'b0000, ctl_q.rst};
    assign mode_o      = ctl_q.mode;
    assign rst_pulse_o = ctl_q.rst;

    // R10: reset bit write yields a pulse and keeps the mode bit written with it
    a_r10_rst_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && wdata_i[0]) |=> (rst_pulse_o && mode_o == $past(wdata_i[7])));

    // R10: without a reset-bit write there is no pulse
    a_r10_no_spurious_rst: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_i && wdata_i[0]) |=> !rst_pulse_o);

    // R9: breakpoint enable follows the written bit
    a_r9_brk_stored: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |=> rdata_o[6] == $past(wdata_i[6]));

endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbgseq_pkg::*;
#(
    parameter int MAX_LEN = INSTR_MAX,
    localparam int LW     = $clog2(MAX_LEN + 1)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          en_i,
    input  logic                          valid_i,
    input  logic [BYTE_W-1:0]             byte_i,
    output logic                          step_o,
    output logic                          fetch_o,
    output logic [LW-1:0]                 len_o,
    output logic [MAX_LEN-1:0][BYTE_W-1:0] bytes_o
);

    typedef struct packed {
        seq_state_e                    st;
        logic [LW-1:0]                 len;
        logic [LW-1:0]                 left;
        logic [MAX_LEN-1:0][BYTE_W-1:0] buff;
        logic                          step;
        logic                          fetch;
        logic [LW-1:0]                 olen;
    } seq_t;

    seq_t s_d, s_q;
    logic [LW-1:0] new_len;

    assign new_len = LW'(op_len(byte_i[7:4]));

    always_comb begin
        s_d      = s_q;
        s_d.step = 1'b0;
        if (valid_i) begin
            unique case (s_q.st)
                S_IDLE: begin
                    if (byte_i == CMD_STEP) begin
                        if (en_i) begin
                            s_d.step  = 1'b1;
                            s_d.fetch = 1'b1;
                            s_d.olen  = '0;
                        end
                    end else if (byte_i == CMD_STUFF) begin
                        if (en_i) s_d.st = S_STUFF;
                    end else if (byte_i == CMD_EXEC) begin
                        s_d.st = en_i ? S_OPC : S_DROP;
                    end
                end
                S_STUFF: begin
                    s_d.buff[0] = byte_i;
                    s_d.step    = 1'b1;
                    s_d.fetch   = 1'b1;
                    s_d.olen    = LW'(1);
                    s_d.st      = S_IDLE;
                end
                S_OPC: begin
                    s_d.buff[0] = byte_i;
                    s_d.len     = new_len;
                    s_d.left    = new_len - LW'(1);
                    if (new_len == LW'(1)) begin
                        s_d.step  = 1'b1;
                        s_d.fetch = 1'b0;
                        s_d.olen  = new_len;
                        s_d.st    = S_IDLE;
                    end else begin
                        s_d.st = S_BODY;
                    end
                end
                S_BODY: begin
                    s_d.buff[s_q.len - s_q.left] = byte_i;
                    s_d.left = s_q.left - LW'(1);
                    if (s_q.left == LW'(1)) begin
                        s_d.step  = 1'b1;
                        s_d.fetch = 1'b0;
                        s_d.olen  = s_q.len;
                        s_d.st    = S_IDLE;
                    end
                end
                S_DROP:  s_d.st = S_IDLE;
                default: s_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: S_IDLE, default: '0};
        else        s_q <= s_d;
    end

    assign step_o  = s_q.step;
    assign fetch_o = s_q.fetch;
    assign len_o   = s_q.olen;
    assign bytes_o = s_q.buff;

    // R6: the byte consumed by a refused execute never causes a request
    a_r6_drop_silent: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_DROP) |=> !step_o);

    // R7: unknown byte while idle is dropped
    a_r7_unknown_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == S_IDLE && valid_i && byte_i != CMD_STEP && byte_i != CMD_STUFF
         && byte_i != CMD_EXEC) |=> (!step_o && s_q.st == S_IDLE));

    // R2/R3: memory-fetch requests inject at most the first byte
    a_r3_fetch_len: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && fetch_o) |-> (len_o <= LW'(1)));

    // R4: host-supplied instruction has a legal length
    a_r4_exec_len: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o && !fetch_o) |-> (len_o >= LW'(1) && len_o <= LW'(MAX_LEN)));

    // R8: no request without a byte in the previous cycle
    a_r8_step_needs_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !step_o);

endmodule

// File: rtl/dbg_step_ctl.sv
module dbg_step_ctl
    import dbgseq_pkg::*;
#(
    parameter int MAX_LEN = INSTR_MAX,
    localparam int LW     = $clog2(MAX_LEN + 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rx_valid_i,
    input  logic [7:0]                rx_byte_i,
    input  logic                      rd_protect_i,
    input  logic                      cpu_halted_i,
    input  logic                      ctl_we_i,
    input  logic [7:0]                ctl_wdata_i,
    output logic [7:0]                ctl_rdata_o,
    output logic                      dev_rst_o,
    output logic                      step_o,
    output logic                      fetch_rest_o,
    output logic [LW-1:0]             inj_len_o,
    output logic [MAX_LEN*BYTE_W-1:0] inj_bytes_o
);

    logic                           mode;
    logic                           step_en;
    logic [MAX_LEN-1:0][BYTE_W-1:0] bytes;

    assign step_en = mode && !rd_protect_i;

    dbg_ctl_reg u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .we_i        (ctl_we_i),
        .wdata_i     (ctl_wdata_i),
        .halted_i    (cpu_halted_i),
        .rdata_o     (ctl_rdata_o),
        .mode_o      (mode),
        .rst_pulse_o (dev_rst_o)
    );

    dbg_cmd_seq #(.MAX_LEN(MAX_LEN)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (step_en),
        .valid_i (rx_valid_i),
        .byte_i  (rx_byte_i),
        .step_o  (step_o),
        .fetch_o (fetch_rest_o),
        .len_o   (inj_len_o),
        .bytes_o (bytes)
    );

    for (genvar g = 0; g < MAX_LEN; g++) begin : g_flat
        assign inj_bytes_o[g*BYTE_W +: BYTE_W] = bytes[g];
    end

    // R5: a request only follows a byte seen while enabled or mid-command
    a_r5_gate_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode && !step_en && rx_valid_i && rx_byte_i == CMD_STEP && !ctl_we_i
         && $past(!mode)) |=> !(step_o && fetch_rest_o && inj_len_o == '0));

endmodule

// File: tb/test_dbg_step_ctl.sv
module test_dbg_step_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_byte = '0;
    logic        protect = 1'b0;
    logic        halted = 1'b0;
    logic        we = 1'b0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic        dev_rst, step, fetch;
    logic [2:0]  len;
    logic [39:0] bytes;

    int tests = 0;
    int fails = 0;
    bit done = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    dbg_step_ctl i_dbg_step_ctl (
        .clk(clk), .rst_n(rst_n), .rx_valid_i(rx_valid), .rx_byte_i(rx_byte),
        .rd_protect_i(protect), .cpu_halted_i(halted), .ctl_we_i(we),
        .ctl_wdata_i(wd), .ctl_rdata_o(rdata), .dev_rst_o(dev_rst),
        .step_o(step), .fetch_rest_o(fetch), .inj_len_o(len), .inj_bytes_o(bytes)
    );

    // Behavioural reference model
    int         m_ph;      // 0 idle, 1 stuff payload, 2 opcode, 3 body, 4 discard
    int         m_need;
    logic [7:0] m_q[$];
    logic       m_mode, m_brk, m_en;
    logic       e_step, e_fetch, e_rst;
    int         e_len;
    logic [7:0] e_bytes[5];

    task automatic issue(input logic f);
        e_step  = 1;
        e_fetch = f;
        e_len   = m_q.size();
        foreach (m_q[i]) e_bytes[i] = m_q[i];
    endtask

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_ph = 0; m_need = 0; m_q = {}; m_mode = 0; m_brk = 0;
            e_step = 0; e_fetch = 0; e_rst = 0; e_len = 0;
        end else begin
            m_en   = m_mode && !protect;
            e_step = 0;
            e_rst  = 0;
            if (rx_valid) begin
                case (m_ph)
                    0: begin
                        if (rx_byte == 8'h10 && m_en) begin m_q = {}; issue(1); end
                        else if (rx_byte == 8'h11 && m_en) m_ph = 1;
                        else if (rx_byte == 8'h12) m_ph = m_en ? 2 : 4;
                    end
                    1: begin m_q = {rx_byte}; issue(1); m_ph = 0; end
                    2: begin
                        m_q = {rx_byte};
                        m_need = (int'(rx_byte[7:4]) % 5);
                        if (m_need == 0) begin issue(0); m_ph = 0; end
                        else m_ph = 3;
                    end
                    3: begin
                        m_q.push_back(rx_byte);
                        m_need--;
                        if (m_need == 0) begin issue(0); m_ph = 0; end
                    end
                    default: m_ph = 0;
                endcase
            end
            if (we) begin
                m_mode = wd[7];
                m_brk  = wd[6];
                e_rst  = wd[0];
            end
        end
    end

    task automatic chk(input bit ok, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    // Compare on every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            logic [7:0] er;
            er = {m_mode, m_brk, halted, 4'b0000, e_rst};
            chk(step === e_step, "step", 64'(step), 64'(e_step));
            chk(dev_rst === e_rst, "dev_rst", 64'(dev_rst), 64'(e_rst));
            chk(rdata === er, "ctl_rdata", 64'(rdata), 64'(er));
            if (e_step) begin
                chk(fetch === e_fetch, "fetch_rest", 64'(fetch), 64'(e_fetch));
                chk(int'(len) == e_len, "inj_len", 64'(len), 64'(e_len));
                for (int i = 0; i < e_len; i++)
                    chk(bytes[i*8 +: 8] === e_bytes[i], "inj_byte",
                        64'(bytes[i*8 +: 8]), 64'(e_bytes[i]));
            end
        end
    end

    task automatic send(input logic [7:0] b);
        rx_valid = 1; rx_byte = b;
        @(negedge clk);
        rx_valid = 0; rx_byte = 8'h00;
    endtask

    task automatic wr(input logic [7:0] v);
        we = 1; wd = v;
        @(negedge clk);
        we = 0; wd = 8'h00;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    int steps_seen = 0;
    always @(negedge clk) if (step) steps_seen++;

    initial begin
        #(20 * 100000);
        if (!done) begin
            done = 1;
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int s0;
        idle(3);
        rst_n = 1;
        cur_req = "R1";
        idle(2);
        halted = 1; idle(1); halted = 0; idle(1);

        // R5: stepping refused before debug mode is entered
        cur_req = "R5";
        send(8'h10); send(8'h11); send(8'h10); idle(2);

        // R10: reset and stop
        cur_req = "R10";
        wr(8'h81); idle(2);

        cur_req = "R2";
        send(8'h10); idle(2);

        cur_req = "R3";
        send(8'h11); idle(1); send(8'hAB); idle(2);

        cur_req = "R4";
        send(8'h12); send(8'h00); idle(1);
        send(8'h12); send(8'h30); send(8'h01); idle(1); send(8'h02); send(8'h03); idle(1);
        send(8'h12); send(8'h40); send(8'hA1); send(8'hA2); send(8'hA3); send(8'hA4); idle(1);
        send(8'h12); send(8'h50); idle(1);
        send(8'h12); send(8'hF0); idle(1);
        send(8'h12); send(8'h9C); send(8'h55); send(8'h66); send(8'h77); send(8'h88); idle(2);

        // R8: command-valued payload, then back-to-back commands
        cur_req = "R8";
        send(8'h12); send(8'h20); send(8'h10); send(8'h12); idle(1);
        send(8'h10); send(8'h10); send(8'h11); send(8'h12); idle(2);

        cur_req = "R7";
        s0 = steps_seen;
        send(8'h33); send(8'hFF); idle(1);
        chk(steps_seen == s0, "unknown bytes step count", 64'(steps_seen), 64'(s0));
        send(8'h10); idle(2);

        // R6: refused execute eats exactly one byte
        cur_req = "R6";
        protect = 1;
        send(8'h12);
        protect = 0;
        s0 = steps_seen;
        send(8'h10); idle(1);
        chk(steps_seen == s0, "discarded byte step count", 64'(steps_seen), 64'(s0));
        send(8'h10); idle(2);
        chk(steps_seen == s0 + 1, "step after discard", 64'(steps_seen), 64'(s0 + 1));

        cur_req = "R5";
        protect = 1;
        s0 = steps_seen;
        send(8'h11); send(8'h10); send(8'h11); idle(2);
        protect = 0;
        chk(steps_seen == s0, "locked step count", 64'(steps_seen), 64'(s0));

        cur_req = "R9";
        wr(8'hFE); halted = 1; idle(2);
        wr(8'h80); halted = 0; idle(2);

        // R10: reset and run, then debug mode off
        cur_req = "R10";
        wr(8'h41); idle(2);
        s0 = steps_seen;
        send(8'h10); send(8'h12); send(8'h10); send(8'h10); idle(2);
        chk(steps_seen == s0, "stepping while running", 64'(steps_seen), 64'(s0));
        wr(8'h81); wr(8'h01); idle(1);
        wr(8'h80); wr(8'h40); idle(2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule